// File: doc/BRIEF.md
# Hashed Page Table Walker

The walker finds the page table entry for one virtual page in a hashed page table held in memory. The caller supplies a 24-bit virtual segment ID, the 28-bit offset of the access within its 256 MB segment, a store flag, and the base and size mask of the table. The walker computes a hash from the segment ID and the page index and searches the 8-entry group that the hash selects. If no entry in that group matches, it searches a second group that the complemented hash selects. Each entry is two 32-bit words, and the walker fetches them one word at a time over a read port that uses a request/valid handshake.

On a hit the walker returns both entry words, the byte offset of the entry inside the table and the translated real address. It then updates the entry's status bits with single-byte writes: the referenced byte, and for stores the changed byte. For a load that finds the changed bit clear, it marks the result as not writable, so that a later store comes back through the walker and sets that bit. On a miss it reports not-found after all 16 entries have been read. Permission checks, fault reporting and translation caching are left to the caller.

Top module: `ptw_walker`

## Requirements
- R1: The primary group offset is `((vsid XOR pidx) << 6) AND tbl_mask`, where `pidx` is `seg_off[27:12]` zero-extended. A primary hit reports `pte_off` = group offset + 8 × slot.
- R2: When the primary group holds no match, the walker searches the group at `((NOT (vsid XOR pidx)) << 6) AND tbl_mask`, with the hash taken 32 bits wide. The primary search uses 16 reads, so a secondary hit in slot k costs 16 + 2(k+1) reads in total.
- R3: Within a group the slots are read in ascending offset order. The lowest slot that matches is returned. A hit in slot k of a group costs 2(k+1) reads in that group.
- R4: A word 0 matches only if all of the following hold: bit 31 (valid) is 1; bit 6 (hash select) equals the pass (0 for primary, 1 for secondary); bits 30:7 equal `vsid`; bits 5:0 equal `pidx[15:10]`.
- R5: For each slot, word 0 (entry address) is read before word 1 (entry address + 4). The read addresses are `tbl_base` + entry offset.
- R6: If bit 8 (referenced) of word 1 is clear, the walker writes one byte to entry address + 6. The byte's value is word 1 bits 15:8 ORed with 0x01.
- R7: If bit 7 (changed) of word 1 is clear and `is_store` is 1, the walker writes one byte to entry address + 7. The byte's value is word 1 bits 7:0 ORed with 0x80. In all other cases no such write is made. `keep_write` equals word 1 bit 7 OR `is_store`.
- R8: On a hit, `real_addr` is word 1 bits 31:12 followed by `seg_off[11:0]`.
- R9: If neither group matches, the walk ends with `hit` = 0 after exactly 32 reads, and no byte write is made.
- R10: `rd_req` and `rd_addr` hold steady until `rd_valid` arrives. The result does not depend on the read latency.
- R11: `done` is a single-cycle pulse that ends each walk. `rd_req` and `wb_en` are low whenever `busy` is low.
- R12: After reset, `busy`, `done`, `hit`, `rd_req` and `wb_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (accepted while idle) |
| seg_vsid | input | 24 | Virtual segment ID |
| seg_off | input | 28 | Access offset within the segment |
| is_store | input | 1 | Access is a store |
| tbl_base | input | 32 | Table base address (64-byte aligned, stable during a walk) |
| tbl_mask | input | 32 | Table offset mask |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| hit | output | 1 | Entry found (valid with done) |
| pte_w0 | output | 32 | Matched entry word 0 |
| pte_w1 | output | 32 | Matched entry word 1 |
| pte_off | output | 32 | Byte offset of matched entry in table |
| real_addr | output | 32 | Translated real address |
| keep_write | output | 1 | Write permission may be kept |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read word address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| wb_en | output | 1 | Byte write strobe |
| wb_addr | output | 32 | Byte write address |
| wb_data | output | 8 | Byte write data |

## Verification
The assertions check several rules on every cycle:
- the read address holds through a stall;
- the first read of a walk is a word 0, and word 1 of the same entry follows it;
- referenced-byte writes carry bit 0 set and changed-byte writes carry bit 7 set;
- a reported hit has a valid word 0 and a real address built from the page number field;
- `done` lasts one cycle, and the ports stay quiet while idle.

Only the bench scenarios can show the rest:
- the hash and group arithmetic;
- that the lowest matching slot wins;
- the exact read count and order;
- rejection of invalid, wrong-tag and wrong-pass entries;
- the store/load split in the changed-bit handling.

The bench sweeps every slot in both groups under several read latencies.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD1, S_SET_R, S_SET_C, S_FIN
  } walk_state_e;

  // Field positions inside the two entry words
  localparam int unsigned W0_VALID  = 31;
  localparam int unsigned W0_HSEL   = 6;
  localparam int unsigned W1_REF    = 8;
  localparam int unsigned W1_CHG    = 7;
  // Byte offsets of the status bytes inside an entry (big-endian)
  localparam int unsigned REF_BYTE  = 6;
  localparam int unsigned CHG_BYTE  = 7;
  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/ptw_hash.sv
module ptw_hash #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned VSID_W    = 24,
  parameter int unsigned PIDX_W    = 16,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned API_W     = 6,
  parameter int unsigned GRP_SHIFT = 6
) (
  input  logic [VSID_W-1:0]           vsid,
  input  logic [PAGE_BITS+PIDX_W-1:0] seg_off,
  input  logic [ADDR_W-1:0]           mask,
  output logic [API_W-1:0]            api,
  output logic [ADDR_W-1:0]           prim_off,
  output logic [ADDR_W-1:0]           sec_off
);
  logic [PIDX_W-1:0] pidx;
  logic [ADDR_W-1:0] hash_w;

  assign pidx     = seg_off[PAGE_BITS +: PIDX_W];
  assign api      = pidx[PIDX_W-1 -: API_W];
  assign hash_w   = ADDR_W'(vsid) ^ ADDR_W'(pidx);
  assign prim_off = (hash_w << GRP_SHIFT) & mask;
  assign sec_off  = ((~hash_w) << GRP_SHIFT) & mask;
endmodule

// File: rtl/ptw_match.sv
module ptw_match import ptw_pkg::*; #(
  parameter int unsigned VSID_W = 24,
  parameter int unsigned API_W  = 6
) (
  input  logic [31:0]       w0,
  input  logic              pass,
  input  logic [VSID_W-1:0] vsid,
  input  logic [API_W-1:0]  api,
  output logic              match
);
  assign match = w0[W0_VALID]
              && (w0[W0_HSEL] == pass)
              && (w0[W0_HSEL+1 +: VSID_W] == vsid)
              && (w0[0 +: API_W] == api);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker import ptw_pkg::*; #(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned VSID_W        = 24,
  parameter int unsigned PIDX_W        = 16,
  parameter int unsigned PAGE_BITS     = 12,
  parameter int unsigned API_W         = 6,
  parameter int unsigned GROUP_ENTRIES = 8,
  parameter int unsigned ENTRY_BYTES   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [VSID_W-1:0]           seg_vsid,
  input  logic [PAGE_BITS+PIDX_W-1:0] seg_off,
  input  logic                        is_store,
  input  logic [ADDR_W-1:0]           tbl_base,
  input  logic [ADDR_W-1:0]           tbl_mask,
  output logic                        busy,
  output logic                        done,
  output logic                        hit,
  output logic [31:0]                 pte_w0,
  output logic [31:0]                 pte_w1,
  output logic [ADDR_W-1:0]           pte_off,
  output logic [31:0]                 real_addr,
  output logic                        keep_write,
  output logic                        rd_req,
  output logic [ADDR_W-1:0]           rd_addr,
  input  logic                        rd_valid,
  input  logic [31:0]                 rd_data,
  output logic                        wb_en,
  output logic [ADDR_W-1:0]           wb_addr,
  output logic [7:0]                  wb_data
);
  localparam int unsigned GRP_SHIFT = $clog2(GROUP_ENTRIES * ENTRY_BYTES);
  localparam int unsigned ESHIFT    = $clog2(ENTRY_BYTES);
  localparam int unsigned IDX_W     = $clog2(GROUP_ENTRIES);
  localparam int unsigned OFF_W     = PAGE_BITS + PIDX_W;

  walk_state_e             state;
  logic [VSID_W-1:0]       vsid_q;
  logic [OFF_W-1:0]        off_q;
  logic                    st_q;
  logic                    pass_q;
  logic [IDX_W-1:0]        idx_q;
  logic [31:0]             w0_q;

  logic [API_W-1:0]        api_c;
  logic [ADDR_W-1:0]       prim_off, sec_off, grp_off, ent_off, ent_addr;
  logic                    match_c;

  ptw_hash #(
    .ADDR_W(ADDR_W), .VSID_W(VSID_W), .PIDX_W(PIDX_W),
    .PAGE_BITS(PAGE_BITS), .API_W(API_W), .GRP_SHIFT(GRP_SHIFT)
  ) u_hash (
    .vsid(vsid_q), .seg_off(off_q), .mask(tbl_mask),
    .api(api_c), .prim_off(prim_off), .sec_off(sec_off)
  );

  ptw_match #(.VSID_W(VSID_W), .API_W(API_W)) u_match (
    .w0(w0_q), .pass(pass_q), .vsid(vsid_q), .api(api_c), .match(match_c)
  );

  assign grp_off  = pass_q ? sec_off : prim_off;
  assign ent_off  = grp_off + (ADDR_W'(idx_q) << ESHIFT);
  assign ent_addr = tbl_base + ent_off;
  assign busy     = (state != S_IDLE);
  assign rd_req   = (state == S_RD0) || (state == S_RD1);
  assign rd_addr  = (state == S_RD1) ? ent_addr + ADDR_W'(WORD_BYTES) : ent_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      done       <= 1'b0;
      hit        <= 1'b0;
      wb_en      <= 1'b0;
      wb_addr    <= '0;
      wb_data    <= '0;
      vsid_q     <= '0;
      off_q      <= '0;
      st_q       <= 1'b0;
      pass_q     <= 1'b0;
      idx_q      <= '0;
      w0_q       <= '0;
      pte_w0     <= '0;
      pte_w1     <= '0;
      pte_off    <= '0;
      real_addr  <= '0;
      keep_write <= 1'b0;
    end else begin
      done  <= 1'b0;
      wb_en <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          vsid_q <= seg_vsid;
          off_q  <= seg_off;
          st_q   <= is_store;
          pass_q <= 1'b0;
          idx_q  <= '0;
          hit    <= 1'b0;
          state  <= S_RD0;
        end
        S_RD0: if (rd_valid) begin
          w0_q  <= rd_data;
          state <= S_RD1;
        end
        S_RD1: if (rd_valid) begin
          if (match_c) begin
            pte_w0     <= w0_q;
            pte_w1     <= rd_data;
            pte_off    <= ent_off;
            real_addr  <= {rd_data[31:PAGE_BITS], off_q[PAGE_BITS-1:0]};
            keep_write <= rd_data[W1_CHG] | st_q;
            state      <= S_SET_R;
          end else if (idx_q == IDX_W'(GROUP_ENTRIES - 1)) begin
            if (pass_q) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              pass_q <= 1'b1;
              idx_q  <= '0;
              state  <= S_RD0;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
            state <= S_RD0;
          end
        end
        S_SET_R: begin
          if (!pte_w1[W1_REF]) begin
            wb_en   <= 1'b1;
            wb_addr <= tbl_base + pte_off + ADDR_W'(REF_BYTE);
            wb_data <= pte_w1[15:8] | 8'h01;
          end
          state <= S_SET_C;
        end
        S_SET_C: begin
          if (!pte_w1[W1_CHG] && st_q) begin
            wb_en   <= 1'b1;
            wb_addr <= tbl_base + pte_off + ADDR_W'(CHG_BYTE);
            wb_data <= pte_w1[7:0] | 8'h80;
          end
          state <= S_FIN;
        end
        S_FIN: begin
          done  <= 1'b1;
          hit   <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  busy,
  input logic                  done,
  input logic                  hit,
  input logic                  w0_valid,
  input logic [31-PAGE_BITS:0] w1_rpn,
  input logic [31-PAGE_BITS:0] ra_page,
  input logic                  rd_req,
  input logic [ADDR_W-1:0]     rd_addr,
  input logic                  rd_valid,
  input logic                  wb_en,
  input logic [2:0]            wb_low,
  input logic [7:0]            wb_data
);
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr)); // R10
  AST_FIRST_WORD0: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |-> rd_addr[2:0] == 3'd0); // R5
  AST_WORD1_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_valid && !rd_addr[2] |=> rd_req && rd_addr == $past(rd_addr) + ADDR_W'(4)); // R5
  AST_REF_BYTE: assert property (@(posedge clk) disable iff (rst)
    wb_en && wb_low == 3'd6 |-> wb_data[0]); // R6
  AST_CHG_BYTE: assert property (@(posedge clk) disable iff (rst)
    wb_en && wb_low == 3'd7 |-> wb_data[7]); // R7
  AST_HIT_VALID: assert property (@(posedge clk) disable iff (rst)
    done && hit |-> w0_valid); // R4
  AST_HIT_RADDR: assert property (@(posedge clk) disable iff (rst)
    done && hit |-> ra_page == w1_rpn); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_req && !wb_en); // R11
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .hit(hit),
  .w0_valid(pte_w0[31]), .w1_rpn(pte_w1[31:PAGE_BITS]), .ra_page(real_addr[31:PAGE_BITS]),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .wb_en(wb_en), .wb_low(wb_addr[2:0]), .wb_data(wb_data)
);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] MASK = 32'h0000_03FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] seg_vsid = '0;
  logic [27:0] seg_off = '0;
  logic        is_store = 1'b0;
  logic        busy, done, hit, keep_write, rd_req, wb_en;
  logic [31:0] pte_w0, pte_w1, pte_off, real_addr, rd_addr, wb_addr;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic [7:0]  wb_data;

  always #2.5 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst(rst), .start(start), .seg_vsid(seg_vsid), .seg_off(seg_off),
    .is_store(is_store), .tbl_base(BASE), .tbl_mask(MASK),
    .busy(busy), .done(done), .hit(hit), .pte_w0(pte_w0), .pte_w1(pte_w1),
    .pte_off(pte_off), .real_addr(real_addr), .keep_write(keep_write),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  logic [31:0] mem [0:255];
  logic [31:0] rlog [0:63];
  logic [31:0] wlog_a [0:7];
  logic [7:0]  wlog_d [0:7];
  int lat = 0, wcnt = 0, nreads = 0, nwr = 0;
  int n_chk = 0, n_fail = 0;

  // memory model, acts on falling edges
  always @(negedge clk) begin
    if (rd_valid) begin
      rd_valid = 1'b0;
      wcnt = 0;
    end else if (rd_req) begin
      if (wcnt >= lat) begin
        rd_valid = 1'b1;
        rd_data = mem[(rd_addr - BASE) >> 2];
        if (nreads < 64) rlog[nreads] = rd_addr;
        nreads++;
      end else wcnt++;
    end
    if (wb_en) begin
      mem[(wb_addr - BASE) >> 2][31 - 8*wb_addr[1:0] -: 8] = wb_data;
      if (nwr < 8) begin
        wlog_a[nwr] = wb_addr;
        wlog_d[nwr] = wb_data;
      end
      nwr++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] goff(input logic [23:0] v, input logic [15:0] p, input bit sec);
    logic [31:0] h;
    h = {8'h00, v} ^ {16'h0000, p};
    if (sec) h = ~h;
    return (h << 6) & MASK;
  endfunction

  function automatic logic [31:0] mk_w0(input bit vld, input logic [23:0] v, input bit hs, input logic [5:0] a);
    return {vld, v, hs, a};
  endfunction

  function automatic logic [31:0] mk_w1(input logic [19:0] rpn, input bit r, input bit c);
    return {rpn, 3'b000, r, c, 5'b00000, 2'b10};
  endfunction

  task automatic put(input logic [31:0] g, input int slot, input logic [31:0] w0, input logic [31:0] w1);
    mem[(g >> 2) + slot*2]     = w0;
    mem[(g >> 2) + slot*2 + 1] = w1;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic walk(input logic [23:0] v, input logic [27:0] off, input bit st);
    int t;
    @(negedge clk);
    nreads = 0; nwr = 0;
    seg_vsid = v; seg_off = off; is_store = st; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 walk timeout actual=%0d expected=<2000", t);
    end
  endtask

  // full check of one completed walk
  task automatic verify(input logic [23:0] v, input logic [27:0] off, input bit st,
                        input bit exp_hit, input bit sec, input int slot, input logic [31:0] w1);
    logic [31:0] g, eoff, ea;
    int exp_reads, k;
    bit seq_ok;
    logic [31:0] bad_a, bad_e;
    chk("R4 hit flag", {31'b0, hit}, {31'b0, exp_hit});
    exp_reads = exp_hit ? (sec ? 16 : 0) + 2*(slot+1) : 32;
    chk(exp_hit ? (sec ? "R2 read count" : "R3 read count") : "R9 read count",
        nreads, exp_reads);
    seq_ok = 1'b1; bad_a = '0; bad_e = '0;
    for (int i = 0; i < nreads && i < 64; i++) begin
      ea = BASE + goff(v, off[27:12], i >= 16) + ((i % 16) / 2) * 8 + (i % 2) * 4;
      if (seq_ok && rlog[i] !== ea) begin
        seq_ok = 1'b0; bad_a = rlog[i]; bad_e = ea;
      end
    end
    chk("R5 read order", bad_a, bad_e);
    if (!exp_hit) begin
      chk("R9 no byte writes", nwr, 0);
    end else begin
      g = goff(v, off[27:12], sec);
      eoff = g + slot*8;
      chk(sec ? "R2 entry offset" : "R1 entry offset", pte_off, eoff);
      chk("R4 word1", pte_w1, w1);
      chk("R8 real address", real_addr, {w1[31:12], off[11:0]});
      chk("R7 keep_write", {31'b0, keep_write}, {31'b0, w1[7] | st});
      k = 0;
      if (!w1[8]) begin
        chk("R6 ref write addr", wlog_a[k], BASE + eoff + 6);
        chk("R6 ref write data", {24'b0, wlog_d[k]}, {24'b0, w1[15:8] | 8'h01});
        k++;
      end
      if (!w1[7] && st) begin
        chk("R7 chg write addr", wlog_a[k], BASE + eoff + 7);
        chk("R7 chg write data", {24'b0, wlog_d[k]}, {24'b0, w1[7:0] | 8'h80});
        k++;
      end
      chk("R6 R7 write count", nwr, k);
    end
    @(negedge clk);
    chk("R11 done pulse", {31'b0, done}, 32'd0);
    chk("R11 busy after done", {31'b0, busy}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] v;
    logic [15:0] p;
    logic [27:0] off;
    logic [31:0] w1, gp, gs;
    clear_mem();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R12 reset busy", {31'b0, busy}, 0);
    chk("R12 reset done", {31'b0, done}, 0);
    chk("R12 reset hit", {31'b0, hit}, 0);
    chk("R12 reset rd_req", {31'b0, rd_req}, 0);
    chk("R12 reset wb_en", {31'b0, wb_en}, 0);
    rst = 1'b0;

    // primary hits in every slot, load, R and C clear, varied latency (R1 R3 R6 R7 R10)
    for (int s = 0; s < 8; s++) begin
      clear_mem();
      v = 24'h0A5000 + 24'(s * 'h111);
      p = 16'h1234 + 16'(s * 'h0401);
      off = {p, 12'(s * 'h10A)};
      gp = goff(v, p, 1'b0);
      for (int d = 0; d < s; d++)
        put(gp, d, mk_w0(1'b1, v, 1'b0, p[15:10] ^ 6'h3F), mk_w1(20'h11111, 1'b0, 1'b0));
      w1 = mk_w1(20'hABC00 + 20'(s), 1'b0, 1'b0);
      put(gp, s, mk_w0(1'b1, v, 1'b0, p[15:10]), w1);
      lat = s % 3;
      walk(v, off, 1'b0);
      verify(v, off, 1'b0, 1'b1, 1'b0, s, w1);
    end

    // secondary hits in every slot, store, R set C clear (R2 R4 R7)
    for (int s = 0; s < 8; s++) begin
      clear_mem();
      v = 24'h3C0F00 + 24'(s * 'h2301);
      p = 16'hF00D - 16'(s * 'h0833);
      off = {p, 12'hFFF - 12'(s)};
      gp = goff(v, p, 1'b0);
      gs = goff(v, p, 1'b1);
      put(gp, 0, mk_w0(1'b1, v, 1'b1, p[15:10]), mk_w1(20'h22222, 1'b1, 1'b1));
      for (int d = 1; d < 8; d++)
        put(gp, d, mk_w0(1'b1, v ^ 24'h000100, 1'b0, p[15:10]), mk_w1(20'h33333, 1'b1, 1'b1));
      w1 = mk_w1(20'h5A5A0 + 20'(s), 1'b1, 1'b0);
      put(gs, s, mk_w0(1'b1, v, 1'b1, p[15:10]), w1);
      lat = (s + 1) % 3;
      walk(v, off, 1'b1);
      verify(v, off, 1'b1, 1'b1, 1'b1, s, w1);
    end

    // store with both status bits already set: no writes, write kept (R6 R7)
    clear_mem();
    v = 24'h777777; p = 16'h0042; off = {p, 12'h123};
    w1 = mk_w1(20'hFEDCB, 1'b1, 1'b1);
    put(goff(v, p, 1'b0), 3, mk_w0(1'b1, v, 1'b0, p[15:10]), w1);
    lat = 1;
    walk(v, off, 1'b1);
    verify(v, off, 1'b1, 1'b1, 1'b0, 3, w1);

    // store with R clear, C clear: both writes (R6 R7)
    clear_mem();
    v = 24'h010203; p = 16'h8001; off = {p, 12'h800};
    w1 = mk_w1(20'h0F0F0, 1'b0, 1'b0);
    put(goff(v, p, 1'b0), 6, mk_w0(1'b1, v, 1'b0, p[15:10]), w1);
    lat = 0;
    walk(v, off, 1'b1);
    verify(v, off, 1'b1, 1'b1, 1'b0, 6, w1);

    // two matches in one group: lowest slot wins (R3)
    clear_mem();
    v = 24'hABCDEF; p = 16'h7FFF; off = {p, 12'h00C};
    gp = goff(v, p, 1'b0);
    w1 = mk_w1(20'h00002, 1'b1, 1'b1);
    put(gp, 2, mk_w0(1'b1, v, 1'b0, p[15:10]), w1);
    put(gp, 5, mk_w0(1'b1, v, 1'b0, p[15:10]), mk_w1(20'h00005, 1'b1, 1'b1));
    lat = 2;
    walk(v, off, 1'b0);
    verify(v, off, 1'b0, 1'b1, 1'b0, 2, w1);

    // miss: invalid, wrong pass, wrong tag decoys in both groups (R4 R9)
    clear_mem();
    v = 24'h135790; p = 16'h2468; off = {p, 12'h456};
    gp = goff(v, p, 1'b0);
    gs = goff(v, p, 1'b1);
    put(gp, 0, mk_w0(1'b0, v, 1'b0, p[15:10]), mk_w1(20'h1, 1'b0, 1'b0));
    put(gp, 1, mk_w0(1'b1, v, 1'b1, p[15:10]), mk_w1(20'h2, 1'b0, 1'b0));
    put(gp, 7, mk_w0(1'b1, v ^ 24'h800000, 1'b0, p[15:10]), mk_w1(20'h3, 1'b0, 1'b0));
    put(gs, 0, mk_w0(1'b1, v, 1'b0, p[15:10]), mk_w1(20'h4, 1'b0, 1'b0));
    put(gs, 4, mk_w0(1'b0, v, 1'b1, p[15:10]), mk_w1(20'h5, 1'b0, 1'b0));
    put(gs, 7, mk_w0(1'b1, v, 1'b1, p[15:10] ^ 6'h01), mk_w1(20'h6, 1'b0, 1'b0));
    lat = 1;
    walk(v, off, 1'b1);
    verify(v, off, 1'b1, 1'b0, 1'b0, 0, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule